// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with LRU Replacement

This block sits between a requester and a slower word-addressed memory. Every word address is split into a set number, taken from its low bits, and a tag, made of all the bits above. The set number picks one set of two lines. Both stored tags of that set are compared with the request tag at the same time, and a read that matches returns the word of the matching line one cycle later, with no memory traffic.

A read that matches neither valid line stalls the requester. The block then fetches the word over a valid/ready request port and waits for the memory's response. It installs the word in the chosen line and returns it to the requester. The chosen line is an empty line if the set has one; otherwise it is the line used less recently, tracked by one bit per set.

Stores always go to memory. A store that matches a line also updates that line and counts as a use of it. A store that misses leaves the cache unchanged. Two addresses that share a set can both stay resident, so alternating between them costs only the two first misses.

Top module: `twoWayCache`

## Requirements
- R1: After reset no line is valid, `reqReady` is 1, and `memReqValid` and `respValid` are 0. The first read of any address is therefore a miss.
- R2: The set of a word address is its low log2(NUM_SETS) bits and the tag is the remaining upper bits. A read hits only when a valid line of that set holds an equal tag, and at most one line of a set can match.
- R3: A read that hits and is accepted (`reqValid` and `reqReady` high at a clock edge) raises `respValid` for one cycle at the next edge. It returns the stored word with `respHit`=1 and issues no memory request.
- R4: A read miss drives `memReqValid`=1, `memReqWrite`=0 and `memReqAddr` equal to the request address. It holds them until `memReqReady` is sampled high, and `reqReady` stays 0 for the whole miss. One cycle after `memRespValid` is sampled high, `respValid`=1 with `respData` equal to `memRespData` and `respHit`=0.
- R5: On a read miss, way 0 is filled if it is invalid. Otherwise way 1 is filled if it is invalid. Only when both are valid is a valid line replaced.
- R6: When both lines of a set are valid, a read miss replaces the line whose last hit or fill is older. Every read hit and every fill make the other way the next victim.
- R7: A store issues a memory request with `memReqWrite`=1, the store address and data. It raises `respValid` one cycle after `memReqReady` is sampled, with `respHit` telling whether the address was cached and `respData` equal to the store data. A hit updates the cached word; a miss allocates no line.
- R8: A store that hits counts as a use of the matching line for replacement.
- R9: With 2 sets, starting from an empty set 0, the read addresses 0,4,0,4,0,4,0,4 give exactly 2 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents an access |
| reqWrite | input | 1 | 1 = store, 0 = read |
| reqAddr | input | ADDR_W | Word address of the access |
| reqWData | input | DATA_W | Store data |
| reqReady | output | 1 | Block can accept an access this cycle |
| respValid | output | 1 | One-cycle completion pulse |
| respHit | output | 1 | The completed access found its address cached |
| respData | output | DATA_W | Read word, or store data for stores |
| memReqValid | output | 1 | Memory request pending |
| memReqWrite | output | 1 | Memory request is a store |
| memReqAddr | output | ADDR_W | Memory request address |
| memReqWData | output | DATA_W | Memory store data |
| memReqReady | input | 1 | Memory accepts the request |
| memRespValid | input | 1 | Memory returns the read word |
| memRespData | input | DATA_W | Returned read word |

## Verification
A wrong valid bit, tag or LRU bit does not show at once. It shows on a later read of that set, as a `respHit` of the wrong polarity, a memory request that should or should not appear, or stale `respData`. This happens within a few accesses of the same set. The bench therefore keeps its own model of every line and of the memory contents. It compares the hit flag, the returned word and the presence of memory traffic on every access. It sweeps all orderings of three competing tags in one set, every address, and a long mixed stream of reads and stores with varying memory latency, so that a corrupted replacement choice is caught on the next conflicting access.

// File: rtl/cachePkg.sv
`timescale 1ns/1ps
package cachePkg;
  localparam int NUM_WAYS = 2;
  localparam int WAY_W    = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEMREQ = 2'd1,
    ST_WAIT   = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic capture;     // latch request address, data and hit flag
    logic touchHit;    // accepted access hit: refresh LRU of its set
    logic writeHit;    // store hit: overwrite the matching line
    logic fill;        // install returned word in the victim line
    logic respHitLd;   // load response from the hit line
    logic respFillLd;  // load response from memory word
    logic respWrLd;    // load store completion
  } ctrlStrobes_t;
endpackage

// File: rtl/cacheDatapath.sv
`timescale 1ns/1ps
module cacheDatapath
  import cachePkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_SETS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] memRespData,
  output logic              lookupHit,
  output logic              hitQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - SET_W;

  logic [NUM_WAYS-1:0] validQ [NUM_SETS];
  logic [TAG_W-1:0]    tagQ   [NUM_WAYS][NUM_SETS];
  logic [DATA_W-1:0]   dataQ  [NUM_WAYS][NUM_SETS];
  logic [NUM_SETS-1:0] lruQ;   // per set: way to replace next

  logic [SET_W-1:0]    lkSet, fSet;
  logic [TAG_W-1:0]    lkTag, fTag;
  logic [NUM_WAYS-1:0] hitVec;
  logic [WAY_W-1:0]    hitWay, victimWay;
  logic [DATA_W-1:0]   hitData;

  assign lkSet = reqAddr[SET_W-1:0];
  assign lkTag = reqAddr[ADDR_W-1:SET_W];
  assign fSet  = addrQ[SET_W-1:0];
  assign fTag  = addrQ[ADDR_W-1:SET_W];

  // One comparator per way, all evaluated in parallel
  for (genvar w = 0; w < NUM_WAYS; w++) begin : gCmp
    assign hitVec[w] = validQ[lkSet][w] && (tagQ[w][lkSet] == lkTag);
  end
  assign lookupHit = |hitVec;

  // Way-select multiplexer
  always_comb begin
    hitWay  = '0;
    hitData = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hitVec[w]) begin
        hitWay  = WAY_W'(w);
        hitData = dataQ[w][lkSet];
      end
    end
  end

  // Victim: lowest invalid way, else the LRU way
  always_comb begin
    victimWay = lruQ[fSet];
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!validQ[fSet][w]) victimWay = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) validQ[s] <= '0;
      lruQ      <= '0;
      addrQ     <= '0;
      wdataQ    <= '0;
      hitQ      <= 1'b0;
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respData  <= '0;
    end else begin
      if (strb.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWData;
        hitQ   <= lookupHit;
      end
      if (strb.touchHit) lruQ[lkSet] <= ~hitWay;
      if (strb.fill) begin
        validQ[fSet][victimWay] <= 1'b1;
        lruQ[fSet]              <= ~victimWay;
      end
      respValid <= strb.respHitLd | strb.respFillLd | strb.respWrLd;
      if (strb.respHitLd) begin
        respData <= hitData;
        respHit  <= 1'b1;
      end else if (strb.respFillLd) begin
        respData <= memRespData;
        respHit  <= 1'b0;
      end else if (strb.respWrLd) begin
        respData <= wdataQ;
        respHit  <= hitQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeHit) dataQ[hitWay][lkSet] <= reqWData;
    if (strb.fill) begin
      tagQ[victimWay][fSet]  <= fTag;
      dataQ[victimWay][fSet] <= memRespData;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec)); // R2
  AST_FILL_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill && !(&validQ[fSet]) |-> !validQ[fSet][victimWay]); // R5
  AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> !hitQ); // R4
  AST_HIT_MOVES_LRU: assert property (@(posedge clk) disable iff (!rstN)
    strb.touchHit |=> lruQ[$past(lkSet)] != $past(hitWay)); // R6
endmodule

// File: rtl/cacheControl.sv
`timescale 1ns/1ps
module cacheControl
  import cachePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         lookupHit,
  input  logic         memReqReady,
  input  logic         memRespValid,
  output ctrlStrobes_t strb,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         memReqWrite
);
  ctrlState_t stateQ, stateD;
  logic       writeQ;

  always_comb begin
    strb        = '0;
    stateD      = stateQ;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capture = 1'b1;
          if (reqWrite) begin
            strb.writeHit = lookupHit;
            strb.touchHit = lookupHit;
            stateD        = ST_MEMREQ;
          end else if (lookupHit) begin
            strb.touchHit  = 1'b1;
            strb.respHitLd = 1'b1;
          end else begin
            stateD = ST_MEMREQ;
          end
        end
      end
      ST_MEMREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          if (writeQ) begin
            strb.respWrLd = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRespValid) begin
          strb.fill       = 1'b1;
          strb.respFillLd = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      writeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.capture) writeQ <= reqWrite;
    end
  end

  assign memReqWrite = writeQ;

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R4
  AST_STALL_DURING_MISS: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R4
  AST_STORE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> !writeQ); // R7
endmodule

// File: rtl/twoWayCache.sv
`timescale 1ns/1ps
module twoWayCache
  import cachePkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_SETS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              reqReady,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  input  logic              memReqReady,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);
  ctrlStrobes_t strb;
  logic         lookupHit;
  logic         hitQ;

  cacheControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .lookupHit    (lookupHit),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .strb         (strb),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite)
  );

  cacheDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SETS (NUM_SETS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqWData    (reqWData),
    .memRespData (memRespData),
    .lookupHit   (lookupHit),
    .hitQ        (hitQ),
    .addrQ       (memReqAddr),
    .wdataQ      (memReqWData),
    .respValid   (respValid),
    .respHit     (respHit),
    .respData    (respData)
  );
endmodule

// File: tb/sim_twoWayCache.sv
`timescale 1ns/1ps
module sim_twoWayCache;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWData = '0;
  logic          reqReady, respValid, respHit;
  logic [DW-1:0] respData;
  logic          memReqValid, memReqWrite;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] memReqWData;
  logic          memReqReady = 1'b0, memRespValid = 1'b0;
  logic [DW-1:0] memRespData = '0;

  always #2.5 clk = ~clk;

  twoWayCache #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(NS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqReady(reqReady),
    .respValid(respValid), .respHit(respHit), .respData(respData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWData(memReqWData),
    .memReqReady(memReqReady), .memRespValid(memRespValid),
    .memRespData(memRespData)
  );

  int checks = 0;
  int fails = 0;
  int missCount = 0;
  bit finished = 0;

  logic [DW-1:0] mem [NA];
  logic          refV   [NS][2];
  int            refTag [NS][2];
  logic [DW-1:0] refD   [NS][2];
  logic          refLru [NS];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAccess(input bit w, input int a, input logic [DW-1:0] d,
                          input int lat, input string req);
    int s;
    int hw;
    int v;
    int cyc;
    bit expHit, expMem, seenMem;
    logic [DW-1:0] expData;
    s  = a % NS;
    hw = -1;
    for (int k = 0; k < 2; k++) if (refV[s][k] && refTag[s][k] == a) hw = k;
    expHit = (hw >= 0);
    if (!w) begin
      if (expHit) begin
        expData   = refD[s][hw];
        refLru[s] = (hw == 0);
      end else begin
        v = !refV[s][0] ? 0 : (!refV[s][1] ? 1 : int'(refLru[s]));
        refV[s][v]   = 1'b1;
        refTag[s][v] = a;
        refD[s][v]   = mem[a];
        refLru[s]    = (v == 0);
        expData      = mem[a];
        missCount++;
      end
      expMem = !expHit;
    end else begin
      if (expHit) begin
        refD[s][hw] = d;
        refLru[s]   = (hw == 0);
      end
      expMem  = 1'b1;
      expData = d;
    end

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = AW'(a); reqWData = d;
    @(negedge clk);
    reqValid = 1'b0;
    seenMem = 0;
    cyc = 0;
    while (!respValid && cyc < 50) begin
      if (memReqValid && !seenMem) begin
        seenMem = 1;
        chk({req, " R4 stall reqReady"}, 32'(reqReady), 32'd0);
        chk({req, " memReqAddr"}, 32'(memReqAddr), 32'(a));
        chk({req, " memReqWrite"}, 32'(memReqWrite), 32'(w));
        if (w) chk({req, " R7 memReqWData"}, 32'(memReqWData), 32'(d));
        repeat (lat) begin
          @(negedge clk);
          chk({req, " R4 request held"}, 32'(memReqValid), 32'd1);
        end
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        if (w) mem[a] = d;
        else begin
          repeat (lat) @(negedge clk);
          memRespValid = 1'b1;
          memRespData  = mem[a];
          @(negedge clk);
          memRespValid = 1'b0;
          memRespData  = '0;
        end
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    chk({req, " respValid"}, 32'(respValid), 32'd1);
    chk({req, " respHit"}, 32'(respHit), 32'(expHit));
    chk({req, " respData"}, 32'(respData), 32'(expData));
    chk({req, " memory traffic"}, 32'(seenMem), 32'(expMem));
  endtask

  initial begin
    int unsigned seed;
    int m0;
    for (int i = 0; i < NA; i++) mem[i] = DW'(i * i * 13 + i * 5 + 7);
    for (int s = 0; s < NS; s++) begin
      refLru[s] = 1'b0;
      for (int k = 0; k < 2; k++) begin
        refV[s][k] = 1'b0; refTag[s][k] = 0; refD[s][k] = '0;
      end
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqReady after reset", 32'(reqReady), 32'd1);
    chk("R1 memReqValid after reset", 32'(memReqValid), 32'd0);
    chk("R1 respValid after reset", 32'(respValid), 32'd0);
    doAccess(0, 5, '0, 1, "R1 first read");

    // R9: ping-pong pair in one set
    m0 = missCount;
    for (int i = 0; i < 8; i++) doAccess(0, (i % 2) ? 4 : 0, '0, 1, "R9");
    chk("R9 miss count", 32'(missCount - m0), 32'd2);

    // R3: repeated hit on resident line
    doAccess(0, 4, '0, 0, "R3 hit");

    // R5 / R6: every ordering of four accesses over three tags in set 0
    for (int q = 0; q < 81; q++) begin
      int t = q;
      for (int j = 0; j < 4; j++) begin
        doAccess(0, 8 + 2 * (t % 3), '0, j % 3, "R6 sweep");
        t = t / 3;
      end
    end

    // R7: store miss allocates nothing; store hit updates line
    doAccess(1, 9, 16'h1234, 1, "R7 store miss");
    doAccess(0, 9, '0, 1, "R7 read after store miss");
    doAccess(0, 11, '0, 0, "R7 prime");
    doAccess(1, 11, 16'hBEEF, 2, "R7 store hit");
    doAccess(0, 11, '0, 0, "R7 read after store hit");

    // R8: store hit refreshes LRU
    doAccess(0, 0, '0, 0, "R8 a");
    doAccess(0, 2, '0, 0, "R8 b");
    doAccess(1, 0, 16'h0F0F, 0, "R8 store touch");
    doAccess(0, 6, '0, 1, "R8 evict");
    doAccess(0, 0, '0, 0, "R8 survivor");

    // R2: every address, read twice
    for (int a = 0; a < NA; a++) begin
      doAccess(0, a, '0, a % 2, "R2 first");
      doAccess(0, a, '0, 0, "R2 second");
    end

    // R3 / R7 mixed stream
    seed = 32'h1ACE5;
    for (int i = 0; i < 1500; i++) begin
      seed = seed * 1103515245 + 12345;
      doAccess(((seed >> 20) % 4) == 0, int'((seed >> 8) % NA),
               DW'(seed >> 3), int'((seed >> 14) % 3), "R3 mixed");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule